// File: doc/BRIEF.md
# Dual-Rail Power-On-Reset Sequencer

This block supervises two supply rails and produces one active-low system reset. Each rail has an enable input and a ready input. Ready is the result of a supply-level comparator; a two-flop synchronizer inside the block brings both inputs into the clock domain. The reset output is held low until an enabled rail turns good, meaning its enable and ready are both high. Once a programmable release delay has then run to completion, the output goes high. After release, a supply that drops pulls the reset low again and restarts the release delay.

A rail that is enabled after the system has already come out of reset would normally drag the reset low while it ramps. To prevent this, its enable rising edge opens a fixed 5 ms mask window, and the output stays high for the whole window. When the window closes, the output stays high only if every enabled rail reports ready. A rail whose enable is low is not required. With no rail enabled, the reset is held low.

Time is counted in units of 50 µs. The parameter `CLK_KHZ` sets the clock rate, and one unit is `CLK_KHZ/20` cycles (at least 1). The two-bit delay select chooses a release delay of 1, 1000, 2000 or 4000 units, which is 50 µs, 50 ms, 100 ms or 200 ms. The mask window is 100 units.

Top module: `dual_rail_por`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is low at once (asynchronously). After reset, `rst_out_n` stays low until a release delay has completed.
- R2: The release delay starts when a rail turns good, either because its ready rises while its enable is high or because its enable rises while its ready is high. `rst_out_n` rises exactly 3 + D·U clock edges after the input change. U is `CLK_KHZ/20`, and D is 1, 1000, 2000 or 4000 for `dly_sel` = 0, 1, 2 or 3.
- R3: While the release delay is counting, a good, enable or ready event on either rail neither restarts it nor extends it.
- R4: The delay length is fixed when the count starts. A change on `dly_sel` during the count has no effect on that count.
- R5: After release, a falling ready on an enabled rail drives `rst_out_n` low 3 edges after the change and restarts the full release delay. The output comes back high when that delay ends, provided all enabled rails are ready by then.
- R6: After release, a rising enable starts a mask window of 100·U cycles. `rst_out_n` stays high throughout the window.
- R7: At the end of the mask window, `rst_out_n` stays high if every enabled rail is ready. Otherwise it falls 3 + 100·U edges after the enable rise. A later good edge of the late rail then starts a normal release delay.
- R8: If both enables rise together and one rail never becomes ready, `rst_out_n` stays low indefinitely.
- R9: A rail with enable low is not required. Disabling one rail while the other is good leaves `rst_out_n` high. With no rail enabled, `rst_out_n` is low within 3 edges, and ready inputs alone have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, rate given by `CLK_KHZ` |
| rst_n | input | 1 | Asynchronous active-low device reset |
| en_a | input | 1 | Enable of rail A |
| en_b | input | 1 | Enable of rail B |
| rdy_a | input | 1 | Supply-ready comparator result of rail A |
| rdy_b | input | 1 | Supply-ready comparator result of rail B |
| dly_sel | input | 2 | Release delay select (0: 50 µs, 1: 50 ms, 2: 100 ms, 3: 200 ms) |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The controller has four states, and each one shows directly at the output. A wrong state appears as an output level that is wrong within three edges of the input change. A state that misses the delay or mask timeout appears as an output that never changes. A timer that is loaded wrongly, or restarted by an event it should ignore, moves the rising or falling edge of the output by a whole number of units. The bench therefore measures the exact edge index of every output transition against the arithmetic 3 + D·U and 3 + 100·U.

// File: rtl/drp_pkg.sv
package drp_pkg;

  localparam int NR        = 2;
  localparam int SEL_W     = 2;
  localparam int SYNC_LEN  = 2;
  localparam int MASK_UNITS = 100;
  localparam logic [SEL_W-1:0] DEF_SEL = 2'b01;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2,
    ST_MASK  = 2'd3
  } drp_state_e;

  // release delay length in 50 us units
  function automatic int unsigned sel_units(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 1000;
      2'd2:    return 2000;
      default: return 4000;
    endcase
  endfunction

  // clock cycles per 50 us unit, never below one
  function automatic int unsigned unit_ticks(input int unsigned khz);
    if (khz / 20 == 0) return 1;
    return khz / 20;
  endfunction

endpackage

// File: rtl/drp_rail_sync.sv
module drp_rail_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic rdy_in,
  output logic en_s,
  output logic good,
  output logic good_rise,
  output logic en_rise,
  output logic rdy_fall
);

  logic [STAGES-1:0] en_pipe;
  logic [STAGES-1:0] rdy_pipe;
  logic              en_d;
  logic              rdy_d;
  logic              rdy_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pipe  <= '0;
      rdy_pipe <= '0;
    end else begin
      en_pipe  <= {en_pipe[STAGES-2:0], en_in};
      rdy_pipe <= {rdy_pipe[STAGES-2:0], rdy_in};
    end
  end

  assign en_s  = en_pipe[STAGES-1];
  assign rdy_s = rdy_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      rdy_d <= 1'b0;
    end else begin
      en_d  <= en_s;
      rdy_d <= rdy_s;
    end
  end

  assign good      = en_s & rdy_s;
  assign good_rise = good & ~(en_d & rdy_d);
  assign en_rise   = en_s & ~en_d;
  assign rdy_fall  = en_s & rdy_d & ~rdy_s;

endmodule

// File: rtl/drp_timer.sv
module drp_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load_ticks,
  input  logic          active,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= load_ticks - CW'(1);
    end else if (!active) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy && active && (cnt == '0);

endmodule

// File: rtl/drp_ctrl.sv
module drp_ctrl
  import drp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] en_s,
  input  logic [NR-1:0] good,
  input  logic [NR-1:0] good_rise,
  input  logic [NR-1:0] en_rise,
  input  logic [NR-1:0] rdy_fall,
  input  logic          dly_done,
  input  logic          msk_done,
  output drp_state_e    st,
  output logic          trig_delay,
  output logic          trig_mask,
  output logic          npor_q
);

  drp_state_e nxt;
  logic       any_en;
  logic       all_ok;

  assign any_en = |en_s;
  assign all_ok = any_en && (&(good | ~en_s));

  always_comb begin
    nxt        = st;
    trig_delay = 1'b0;
    trig_mask  = 1'b0;
    case (st)
      ST_HOLD: begin
        if (any_en && (|good_rise)) begin
          nxt        = ST_DELAY;
          trig_delay = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!any_en)       nxt = ST_HOLD;
        else if (dly_done) nxt = all_ok ? ST_RUN : ST_HOLD;
      end
      ST_RUN: begin
        if (!any_en) begin
          nxt = ST_HOLD;
        end else if (|rdy_fall) begin
          nxt        = ST_DELAY;
          trig_delay = 1'b1;
        end else if (|en_rise) begin
          nxt       = ST_MASK;
          trig_mask = 1'b1;
        end else if (!all_ok) begin
          nxt = ST_HOLD;
        end
      end
      ST_MASK: begin
        if (!any_en)       nxt = ST_HOLD;
        else if (msk_done) nxt = all_ok ? ST_RUN : ST_HOLD;
      end
      default: nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_HOLD;
      npor_q <= 1'b0;
    end else begin
      st     <= nxt;
      npor_q <= (nxt == ST_RUN) || (nxt == ST_MASK);
    end
  end

endmodule

// File: rtl/dual_rail_por.sv
module dual_rail_por
  import drp_pkg::*;
#(
  parameter int CLK_KHZ = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             rdy_a,
  input  logic             rdy_b,
  input  logic [SEL_W-1:0] dly_sel,
  output logic             rst_out_n
);

  localparam int unsigned UNIT      = unit_ticks(CLK_KHZ);
  localparam int unsigned MAX_TICKS = sel_units(2'd3) * UNIT;
  localparam int unsigned MSK_TICKS = MASK_UNITS * UNIT;
  localparam int          CW        = $clog2(MAX_TICKS + 1);

  logic [NR-1:0] en_raw;
  logic [NR-1:0] rdy_raw;
  logic [NR-1:0] en_s;
  logic [NR-1:0] good;
  logic [NR-1:0] good_rise;
  logic [NR-1:0] en_rise;
  logic [NR-1:0] rdy_fall;

  assign en_raw  = {en_b, en_a};
  assign rdy_raw = {rdy_b, rdy_a};

  for (genvar i = 0; i < NR; i++) begin : g_rail
    drp_rail_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_in     (en_raw[i]),
      .rdy_in    (rdy_raw[i]),
      .en_s      (en_s[i]),
      .good      (good[i]),
      .good_rise (good_rise[i]),
      .en_rise   (en_rise[i]),
      .rdy_fall  (rdy_fall[i])
    );
  end

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= DEF_SEL;
    else        sel_q <= dly_sel;
  end

  drp_state_e    st;
  logic          trig_delay;
  logic          trig_mask;
  logic          dly_done;
  logic          msk_done;
  logic          dly_busy;
  logic          msk_busy;
  logic [CW-1:0] dly_cnt;
  logic [CW-1:0] msk_cnt;
  logic [CW-1:0] dly_load;
  logic [CW-1:0] msk_load;
  logic          any_en;

  assign dly_load = CW'(sel_units(sel_q) * UNIT);
  assign msk_load = CW'(MSK_TICKS);
  assign any_en   = |en_s;

  drp_timer #(.CW(CW)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (trig_delay),
    .load_ticks (dly_load),
    .active     (st == ST_DELAY),
    .busy       (dly_busy),
    .cnt        (dly_cnt),
    .done       (dly_done)
  );

  drp_timer #(.CW(CW)) u_msk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (trig_mask),
    .load_ticks (msk_load),
    .active     (st == ST_MASK),
    .busy       (msk_busy),
    .cnt        (msk_cnt),
    .done       (msk_done)
  );

  logic npor_q;

  drp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .good       (good),
    .good_rise  (good_rise),
    .en_rise    (en_rise),
    .rdy_fall   (rdy_fall),
    .dly_done   (dly_done),
    .msk_done   (msk_done),
    .st         (st),
    .trig_delay (trig_delay),
    .trig_mask  (trig_mask),
    .npor_q     (npor_q)
  );

  assign rst_out_n = npor_q;

endmodule

// File: rtl/drp_checker.sv
module drp_checker
  import drp_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_out_n,
  input drp_state_e    st,
  input logic [NR-1:0] good_rise,
  input logic [NR-1:0] en_rise,
  input logic [NR-1:0] rdy_fall,
  input logic          any_en,
  input logic          dly_busy,
  input logic          msk_busy,
  input logic [CW-1:0] dly_cnt,
  input logic [CW-1:0] msk_cnt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (!rst_out_n);
    end
  end

  p_trigger_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && any_en && (|good_rise)) |=> (st == ST_DELAY));

  p_delay_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY) |-> !rst_out_n);

  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY && dly_busy && dly_cnt != '0 && any_en)
      |=> (dly_cnt == $past(dly_cnt) - CW'(1)));

  p_rdy_fall_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && any_en && (|rdy_fall)) |=> (st == ST_DELAY));

  p_late_en_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && any_en && (|en_rise) && !(|rdy_fall)) |=> (st == ST_MASK));

  p_mask_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MASK) |-> rst_out_n);

  p_mask_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MASK && msk_busy && msk_cnt != '0 && any_en)
      |=> (msk_cnt == $past(msk_cnt) - CW'(1)));

  p_none_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !rst_out_n);

endmodule

bind dual_rail_por drp_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_out_n (rst_out_n),
  .st        (st),
  .good_rise (good_rise),
  .en_rise   (en_rise),
  .rdy_fall  (rdy_fall),
  .any_en    (any_en),
  .dly_busy  (dly_busy),
  .msk_busy  (msk_busy),
  .dly_cnt   (dly_cnt),
  .msk_cnt   (msk_cnt)
);

// File: tb/tb_dual_rail_por.sv
`timescale 1ns/1ps
module tb_dual_rail_por;

  localparam int KHZ  = 20;
  localparam int U    = (KHZ / 20 < 1) ? 1 : KHZ / 20;
  localparam int MSK  = 100 * U;
  localparam int LAT  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_a = 1'b0, en_b = 1'b0, rdy_a = 1'b0, rdy_b = 1'b0;
  logic [1:0] dly_sel = 2'd0;
  logic       rst_out_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dual_rail_por #(.CLK_KHZ(KHZ)) dut (
    .clk (clk), .rst_n (rst_n), .en_a (en_a), .en_b (en_b),
    .rdy_a (rdy_a), .rdy_b (rdy_b), .dly_sel (dly_sel),
    .rst_out_n (rst_out_n)
  );

  function automatic int exp_delay(input int s);
    int units;
    units = (s == 0) ? 1 : 1000 * (1 << (s - 1));
    return LAT + units * U;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic first_level(input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (rst_out_n !== lvl && n < limit);
  endtask

  task automatic set_sel(input logic [1:0] s);
    dly_sel = s;
    repeat (5) step();
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    int highs;
    int bad;
    @(negedge clk);
    check(rst_out_n == 1'b0, "R1 low in reset", rst_out_n, 0);
    repeat (3) step();
    rst_n = 1'b1;
    highs = 0;
    for (int i = 0; i < 20; i++) begin step(); highs += rst_out_n; end
    check(highs == 0, "R1 low after reset without trigger", highs, 0);

    // R2: sweep every delay select on rail A
    for (int s = 0; s < 4; s++) begin
      set_sel(2'(s));
      en_a = 1'b1; rdy_a = 1'b1;
      first_level(1'b1, 10000, n);
      check(n == exp_delay(s), $sformatf("R2 release delay sel=%0d", s), n, exp_delay(s));
      en_a = 1'b0;
      first_level(1'b0, 100, n);
      check(n == LAT, "R9 no rail enabled", n, LAT);
      rdy_a = 1'b0;
      repeat (5) step();
    end

    // R3: rail B turning good during the count is ignored
    set_sel(2'd1);
    en_a = 1'b1; rdy_a = 1'b1;
    n = 0;
    do begin
      step(); n++;
      if (n == 300) begin en_b = 1'b1; rdy_b = 1'b1; end
    end while (!rst_out_n && n < 10000);
    check(n == exp_delay(1), "R3 other rail ignored in count", n, exp_delay(1));
    en_a = 0; en_b = 0; rdy_a = 0; rdy_b = 0;
    repeat (10) step();

    // R4: select change mid-count has no effect
    set_sel(2'd3);
    en_a = 1'b1; rdy_a = 1'b1;
    n = 0;
    do begin
      step(); n++;
      if (n == 10) dly_sel = 2'd0;
    end while (!rst_out_n && n < 10000);
    check(n == exp_delay(3), "R4 select latched at start", n, exp_delay(3));

    // R6/R7: late rail B enabled, never ready
    en_b = 1'b1;
    bad = 0;
    for (int i = 1; i <= LAT + MSK; i++) begin
      step();
      if (i < LAT + MSK && !rst_out_n) bad++;
      if (i == LAT + MSK && rst_out_n) bad++;
    end
    check(bad == 0, "R6 R7 mask then drop", bad, 0);

    // R7: later good edge of rail B starts a normal delay (sel 0)
    rdy_b = 1'b1;
    first_level(1'b1, 100, n);
    check(n == exp_delay(0), "R7 late rail release", n, exp_delay(0));

    // R5: ready fall retriggers the full delay
    set_sel(2'd1);
    rdy_a = 1'b0;
    first_level(1'b0, 100, n);
    check(n == LAT, "R5 drop on ready fall", n, LAT);
    do begin
      step(); n++;
      if (n == 10) rdy_a = 1'b1;
    end while (!rst_out_n && n < 10000);
    check(n == exp_delay(1), "R5 retriggered delay", n, exp_delay(1));

    // R9: disabling one rail keeps the output high
    en_b = 1'b0; rdy_b = 1'b0;
    highs = 0;
    for (int i = 0; i < 20; i++) begin step(); highs += rst_out_n; end
    check(highs == 20, "R9 disabled rail not required", highs, 20);

    // R7: late rail ready inside the mask keeps the output high
    en_b = 1'b1;
    highs = 0;
    for (int i = 1; i <= 300; i++) begin
      step();
      if (i == 50) rdy_b = 1'b1;
      highs += rst_out_n;
    end
    check(highs == 300, "R7 mask end with all ready", highs, 300);

    // R8: tied enables, rail B never ready
    en_a = 0; en_b = 0; rdy_a = 0; rdy_b = 0;
    repeat (10) step();
    check(rst_out_n == 1'b0, "R9 all disabled low", rst_out_n, 0);
    en_a = 1'b1; en_b = 1'b1; rdy_a = 1'b1;
    highs = 0;
    for (int i = 0; i < 3000; i++) begin step(); highs += rst_out_n; end
    check(highs == 0, "R8 power fail stays low", highs, 0);

    // R9: ready alone without enable does nothing
    en_a = 0; en_b = 0;
    repeat (5) step();
    rdy_b = 1'b1;
    highs = 0;
    for (int i = 0; i < 50; i++) begin step(); highs += rst_out_n; end
    check(highs == 0, "R9 ready without enable", highs, 0);

    // R2: enable rising while ready already high
    rdy_b = 1'b0;
    repeat (5) step();
    en_a = 1'b1;
    first_level(1'b1, 10000, n);
    check(n == exp_delay(1), "R2 enable-rise trigger", n, exp_delay(1));

    // R1: asynchronous reset forces low
    #1 rst_n = 1'b0;
    #1 check(rst_out_n == 1'b0, "R1 async reset", rst_out_n, 0);
    @(negedge clk);
    set_sel(2'd0);
    rst_n = 1'b1;
    first_level(1'b1, 100, n);
    check(n == exp_delay(0), "R1 R2 restart after reset", n, exp_delay(0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule